// File: doc/BRIEF.md
# Dual 16-bit Timer/Counter

This block holds two independent 16-bit timer/counters, each kept as a low byte and a high byte, set up by one shared mode register and one control register. In timer mode a unit advances on a tick from a shared prescaler that divides the clock by 12 (slow) or by 4 (fast). In counter mode it advances on each falling edge of its own count pin, which is sampled on every clock. A gate input can qualify either kind of counting.

Each unit has four modes: a 13-bit counter, a 16-bit counter, an 8-bit counter reloaded from the high byte, and a split mode. In split mode, unit 0's low byte is an 8-bit counter under unit 0's controls, and its high byte is an 8-bit timer that uses unit 1's run bit and unit 1's flag. A rollover sets a sticky flag that software can read and clear. It also drives a one-cycle pulse that a serial port can use as its baud source. All registers are reached through a small synchronous write port and a combinational read port.

Top module: `tmr_pair`

## Requirements
- R1: After reset every register reads 0x00 and `ovf_pulse` is 0.
- R2: In timer mode a unit advances by one for every 12 clock edges while control bit 2 is 0, and for every 4 clock edges while it is 1. The count of advances in any window of N×divider enabled edges is exactly N.
- R3: In counter mode (mode bit 2 of the unit's nibble set), a unit advances once for each 1-to-0 transition of its `cnt_pin`. The pin is sampled on every clock edge, and the new count becomes visible after the second clock edge following the fall.
- R4: A unit advances only while its run bit is 1: control bit 0 for unit 0 and bit 1 for unit 1. When the unit's gate-enable bit (mode bit 3 of its nibble) is set, its `gate_pin` must also be high. Pin edges and prescaler ticks outside that condition are lost.
- R5: Mode 0 is a 13-bit counter. The low byte's bits 4:0 are the low part and the high byte is the upper part. Low-byte bits 7:5 are kept, and the flag sets when the 13-bit value wraps from 0x1FFF.
- R6: Mode 1 is a 16-bit counter {high, low} that wraps from 0xFFFF to 0x0000 and sets the flag.
- R7: Mode 2 counts in the low byte only. When the low byte steps past 0xFF it is loaded with the high byte, the flag is set, and the high byte is unchanged.
- R8: Mode 3 on unit 0 splits it. The low byte counts under unit 0's controls and sets flag 0. The high byte counts prescaler ticks while run bit 1 is set, and its wrap from 0xFF sets flag 1. Mode 3 on unit 1 freezes unit 1.
- R9: Flags sit in control bit 6 (unit 0) and bit 7 (unit 1). A rollover sets the flag, and writing 0 clears it. A rollover in the same cycle as a write of 0 leaves the flag set.
- R10: `ovf_pulse[i]` is high for exactly one cycle, in the cycle after unit i's own counter rolls over; the high byte in split mode does not drive it.
- R11: Register addresses are: 0 mode (bits 3:0 for unit 0, bits 7:4 for unit 1; in each nibble, bits 1:0 are the mode, bit 2 is counter select and bit 3 is gate enable), 1 control, 2 low byte 0, 3 high byte 0, 4 low byte 1, 5 high byte 1. Written values read back, and a write to a count byte takes priority over counting in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| cnt_pin | input | 2 | External count inputs, one per unit |
| gate_pin | input | 2 | Gate inputs, one per unit |
| ovf_pulse | output | 2 | One-cycle rollover pulses, baud source |

## Verification
A prescaler phase or divider error shows as a count that is off by one or more. This appears at the first byte read after a gate window of exactly N×divider edges, so a window of a few ticks exposes it. A wrong edge detector or sampler shows as a missing or doubled count within two clocks of a pin fall, or as an increment one cycle early. A wrong mode decode or reload path shows as a wrong byte value, or as a wrong flag or pulse, on the very tick that wraps. The sweep places preloads just below each wrap point so that this tick falls inside the window.

// File: rtl/tmr_pair.sv
module tmr_pair #(
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [2:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [1:0] cnt_pin,
  input  logic [1:0] gate_pin,
  output logic [1:0] ovf_pulse
);
  localparam int PW = $clog2(DIV_SLOW);
  localparam logic [2:0] A_MODE = 3'd0, A_CTRL = 3'd1, A_LO0 = 3'd2,
                         A_HI0 = 3'd3, A_LO1 = 3'd4, A_HI1 = 3'd5;

  logic [7:0] mode_q, lo0, hi0, lo1, hi1;
  logic [1:0] run_q, flag_q, ovf_q, smp_q, old_q, fall;
  logic       fast_q, tick;
  logic [PW-1:0] pre_q;

  function automatic logic [16:0] step(input logic [1:0] m, input logic [7:0] h, input logic [7:0] l);
    case (m)
      2'd0: if (l[4:0] == 5'h1f) return {h == 8'hff, h + 8'd1, l[7:5], 5'd0};
            else return {1'b0, h, l[7:5], l[4:0] + 5'd1};
      2'd1: return {1'b0, h, l} + 17'd1;
      2'd2: if (l == 8'hff) return {1'b1, h, h};
            else return {1'b0, h, l + 8'd1};
      default: if (l == 8'hff) return {1'b1, h, 8'h00};
               else return {1'b0, h, l + 8'd1};
    endcase
  endfunction

  wire [PW-1:0] div_m1 = fast_q ? PW'(DIV_FAST - 1) : PW'(DIV_SLOW - 1);
  assign tick = pre_q >= div_m1;
  assign fall = old_q & ~smp_q;

  wire [1:0] m0 = mode_q[1:0];
  wire [1:0] m1 = mode_q[5:4];
  wire en0 = run_q[0] & (~mode_q[3] | gate_pin[0]);
  wire en1 = run_q[1] & (~mode_q[7] | gate_pin[1]);
  wire adv0 = en0 & (mode_q[2] ? fall[0] : tick);
  wire adv1 = en1 & (mode_q[6] ? fall[1] : tick) & (m1 != 2'd3);
  wire split = (m0 == 2'd3);
  wire adv_h0 = split & run_q[1] & tick;

  wire [16:0] nx0 = step(m0, hi0, lo0);
  wire [16:0] nx1 = step(m1, hi1, lo1);
  wire evt0 = adv0 & nx0[16];
  wire evt1 = adv1 & nx1[16];
  wire evt_h = adv_h0 & (hi0 == 8'hff);
  wire [1:0] fset = {split ? evt_h : evt1, evt0};

  wire wr_mode = reg_we && reg_addr == A_MODE;
  wire wr_ctrl = reg_we && reg_addr == A_CTRL;
  wire wr_lo0  = reg_we && reg_addr == A_LO0;
  wire wr_hi0  = reg_we && reg_addr == A_HI0;
  wire wr_lo1  = reg_we && reg_addr == A_LO1;
  wire wr_hi1  = reg_we && reg_addr == A_HI1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0; run_q <= '0; fast_q <= 1'b0; flag_q <= '0; ovf_q <= '0;
      lo0 <= '0; hi0 <= '0; lo1 <= '0; hi1 <= '0;
      pre_q <= '0; smp_q <= '0; old_q <= '0;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      smp_q <= cnt_pin;
      old_q <= smp_q;
      ovf_q <= {evt1, evt0};
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) begin
        run_q  <= reg_wdata[1:0];
        fast_q <= reg_wdata[2];
      end
      for (int i = 0; i < 2; i++)
        flag_q[i] <= fset[i] | (wr_ctrl ? reg_wdata[6+i] : flag_q[i]);

      if (wr_lo0)      lo0 <= reg_wdata;
      else if (adv0)   lo0 <= nx0[7:0];
      if (wr_hi0)      hi0 <= reg_wdata;
      else if (adv_h0) hi0 <= hi0 + 8'd1;
      else if (adv0)   hi0 <= nx0[15:8];
      if (wr_lo1)      lo1 <= reg_wdata;
      else if (adv1)   lo1 <= nx1[7:0];
      if (wr_hi1)      hi1 <= reg_wdata;
      else if (adv1)   hi1 <= nx1[15:8];
    end
  end

  always_comb begin
    case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = {flag_q, 3'b000, fast_q, run_q};
      A_LO0:   reg_rdata = lo0;
      A_HI0:   reg_rdata = hi0;
      A_LO1:   reg_rdata = lo1;
      A_HI1:   reg_rdata = hi1;
      default: reg_rdata = 8'h00;
    endcase
  end

  assign ovf_pulse = ovf_q;
endmodule

// File: rtl/tmr_pair_chk.sv
module tmr_pair_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] reg_addr,
  input logic       tick,
  input logic [1:0] fall,
  input logic [1:0] run_q,
  input logic [1:0] flag_q,
  input logic [1:0] ovf_pulse,
  input logic [7:0] mode_q,
  input logic [7:0] lo1,
  input logic [7:0] hi1
);
  wire wr_ctrl = reg_we && reg_addr == 3'd1;
  wire wr_t1 = reg_we && (reg_addr == 3'd4 || reg_addr == 3'd5);

  // R2
  prescale_chk: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
  // R3
  cnt_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[6] && !fall[1] && !wr_t1) |=> $stable({hi1, lo1}));
  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q[1] && !wr_t1) |=> $stable({hi1, lo1}));
  // R6
  wrap16_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse[1] && mode_q[5:4] == 2'd1 && !$past(reg_we)) |-> ({hi1, lo1} == 16'h0000));
  // R7
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_pulse[1] && mode_q[5:4] == 2'd2 && !$past(reg_we)) |-> (lo1 == hi1));
  // R9
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q[0] && !wr_ctrl) |=> flag_q[0]);
endmodule

bind tmr_pair tmr_pair_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .tick(tick), .fall(fall), .run_q(run_q), .flag_q(flag_q),
  .ovf_pulse(ovf_pulse), .mode_q(mode_q), .lo1(lo1), .hi1(hi1)
);

// File: tb/sim_tmr_pair.sv
module sim_tmr_pair;
  localparam int CLK_PERIOD = 10;
  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [1:0] pin = '0, gate = '0, ovf;
  int checks = 0, errs = 0;
  bit done = 0;

  tmr_pair u0 (.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
               .reg_rdata(rdata), .cnt_pin(pin), .gate_pin(gate), .ovf_pulse(ovf));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(input int i);
    @(negedge clk); pin[i] = 1'b1;
    @(negedge clk); pin[i] = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [16:0] model(input int m, input int h, input int l, input int k);
    int v; logic [7:0] hh, ll; logic o;
    hh = 8'(h); ll = 8'(l); o = 1'b0;
    if (m == 0) begin
      v = h * 32 + (l % 32) + k;
      o = v >= 8192; v = v % 8192;
      hh = 8'(v / 32); ll = {ll[7:5], 5'(v % 32)};
    end else if (m == 1) begin
      v = h * 256 + l + k;
      o = v > 65535; v = v % 65536;
      hh = 8'(v / 256); ll = 8'(v % 256);
    end else begin
      if (l + k <= 255) ll = 8'(l + k);
      else begin o = 1'b1; ll = 8'(h + ((l + k - 256) % (256 - h))); end
    end
    return {o, hh, ll};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errs);
      $finish;
    end
  end

  initial begin
    logic [7:0] r, lo, hi, cr;
    logic [16:0] e;
    int hs[3][3];
    int ls[3][3];
    hs = '{'{255, 0, 18}, '{255, 0, 127}, '{240, 128, 254}};
    ls = '{'{30, 0, 224}, '{254, 16, 255}, '{254, 16, 255}};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), r); chk("R1 reset value", {8'h0, r}, 16'h0);
    end
    chk("R1 ovf_pulse reset", {14'h0, ovf}, 16'h0);

    // R5 R6 R7 sweep, fast prescaler, gate window of 4k edges (R2 R4)
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 3; p++)
        for (int k = 1; k <= 3; k++) begin
          wr(3'd0, 8'(8 + m));
          wr(3'd2, 8'(ls[m][p]));
          wr(3'd3, 8'(hs[m][p]));
          wr(3'd1, 8'h05);
          @(negedge clk); gate[0] = 1'b1;
          repeat (4 * k) @(negedge clk);
          gate[0] = 1'b0;
          repeat (3) @(negedge clk);
          rd(3'd2, lo); rd(3'd3, hi); rd(3'd1, cr);
          e = model(m, hs[m][p], ls[m][p], k);
          if (m == 0) chk("R5 13-bit count", {hi, lo}, e[15:0]);
          else if (m == 1) chk("R6 16-bit count", {hi, lo}, e[15:0]);
          else chk("R7 reload count", {hi, lo}, e[15:0]);
          chk("R9 flag after window", {15'h0, cr[6]}, {15'h0, e[16]});
        end

    rd(3'd0, r); chk("R11 mode readback", {8'h0, r}, 16'h000a);

    // R2 slow prescaler, then R4 gate closed holds the count
    wr(3'd0, 8'h09); wr(3'd2, 8'h00); wr(3'd3, 8'h00); wr(3'd1, 8'h01);
    @(negedge clk); gate[0] = 1'b1;
    repeat (24) @(negedge clk);
    gate[0] = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd2, lo); rd(3'd3, hi);
    chk("R2 divide-by-12 count", {hi, lo}, 16'h0002);
    repeat (30) @(negedge clk);
    rd(3'd2, lo); rd(3'd3, hi);
    chk("R4 gate low holds", {hi, lo}, 16'h0002);

    // R8 split mode; unit 1 in mode 3 frozen
    wr(3'd0, 8'h3b); wr(3'd2, 8'hfe); wr(3'd3, 8'hfd); wr(3'd4, 8'h34); wr(3'd5, 8'h12);
    wr(3'd1, 8'h06);
    repeat (14) @(negedge clk);
    rd(3'd1, cr);
    chk("R8 split high wrap sets flag 1", {14'h0, cr[7:6]}, 16'h0002);
    wr(3'd1, 8'h04);
    rd(3'd3, hi); rd(3'd2, lo);
    chk("R8 split high byte count", {hi, lo}, 16'h01fe);
    rd(3'd5, hi); rd(3'd4, lo);
    chk("R8 unit 1 frozen in mode 3", {hi, lo}, 16'h1234);

    // R3 counter mode on unit 1
    wr(3'd0, 8'h50); wr(3'd4, 8'h00); wr(3'd5, 8'h00); wr(3'd1, 8'h02);
    for (int n = 0; n < 5; n++) pulse(1);
    repeat (2) @(negedge clk);
    rd(3'd4, lo); chk("R3 five falls counted", {8'h0, lo}, 16'h0005);
    @(negedge clk); pin[1] = 1'b1;
    @(negedge clk); pin[1] = 1'b0;
    @(negedge clk); rd(3'd4, lo); chk("R3 not counted after one edge", {8'h0, lo}, 16'h0005);
    @(negedge clk); rd(3'd4, lo); chk("R3 counted after second edge", {8'h0, lo}, 16'h0006);
    wr(3'd0, 8'hd0);
    for (int n = 0; n < 3; n++) pulse(1);
    repeat (2) @(negedge clk);
    rd(3'd4, lo); chk("R4 gated falls ignored", {8'h0, lo}, 16'h0006);
    gate[1] = 1'b1;
    pulse(1); repeat (2) @(negedge clk);
    rd(3'd4, lo); chk("R4 gate open counts", {8'h0, lo}, 16'h0007);
    gate[1] = 1'b0;
    wr(3'd1, 8'h00);
    for (int n = 0; n < 2; n++) pulse(1);
    repeat (2) @(negedge clk);
    rd(3'd4, lo); chk("R4 run off ignores falls", {8'h0, lo}, 16'h0007);

    // R9 R10 collision of overflow and clearing write on unit 0
    wr(3'd0, 8'h05); wr(3'd2, 8'hff); wr(3'd3, 8'hff); wr(3'd1, 8'h01);
    @(negedge clk); pin[0] = 1'b1;
    @(negedge clk); pin[0] = 1'b0;
    @(negedge clk); we = 1'b1; addr = 3'd1; wdata = 8'h01;
    @(negedge clk); we = 1'b0;
    chk("R10 pulse on rollover", {14'h0, ovf}, 16'h0001);
    rd(3'd1, cr); chk("R9 flag kept on same-cycle clear", {15'h0, cr[6]}, 16'h0001);
    rd(3'd2, lo); rd(3'd3, hi); chk("R6 wrap to zero", {hi, lo}, 16'h0000);
    @(negedge clk);
    chk("R10 pulse one cycle", {14'h0, ovf}, 16'h0000);
    wr(3'd1, 8'h01);
    rd(3'd1, cr); chk("R9 flag cleared by write 0", {15'h0, cr[6]}, 16'h0000);
    rd(3'd1, cr); chk("R11 control readback", {8'h0, cr}, 16'h0001);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
    $finish;
  end
endmodule